// File: doc/BRIEF.md
# Local Interrupt Controller Register Window

This block is the memory-mapped front end of a local interrupt controller. It watches a 32-bit address bus and claims every access that falls inside a 4 KB window whose base is supplied on an input. Inside the window it keeps the controller's software-visible configuration: identity, priority, destination, spurious-vector, error status, local vector entries, the timer counts and divider, the command word and the vector-enable bitmap. It also presents the in-service, trigger-mode and request bitmaps owned by the priority core as read-only 32-bit windows.

Accesses use single-cycle read and write strobes. Read data comes back, qualified by a valid flag, in the cycle after the strobe. A global enable gates the whole window. When it is clear, window accesses are refused and an error pulse is raised. The register contents drive field outputs toward the priority core and the timer. A write to the low command word raises a one-cycle send request toward the message logic.

Top module: `intc_regwin`

## Requirements
- R1: After reset the version word reads 0x80050010, destination format reads 0xFFFFFFFF, spurious vector reads 0x000000FF, and each of the six local vector entries (slots 0x320 through 0x370) reads 0x00010000 with mask bit 16 set. Every other stored register reads zero, including the enable bitmap.
- R2: An access is claimed only when bus address bits 31:12 equal base bits 31:12. An unclaimed access gives no valid flag, no error and no register change.
- R3: A claimed read returns its data with `rdValid` high exactly one cycle after `rdStb`. `rdData` is zero whenever `rdValid` is low.
- R4: Offset bits 3:0 are ignored. These registers store and read back all 32 bits: 0x020, 0x080, 0x0D0, 0x0E0, 0x0F0, 0x280, 0x300, 0x310, 0x320–0x370, 0x380, 0x390, 0x3E0, and 0x500–0x530.
- R5: Writes to the version word (0x030), the remote-read word (0x0C0, which reads zero) and the three core bitmaps are ignored.
- R6: The in-service, trigger-mode and request bitmaps read at 0x100+16k, 0x180+16k and 0x200+16k for k = 0..7. Bit j of window k is vector 32k+j.
- R7: The enable bitmap is read/write at 0x480+16k with the same vector layout and drives `enMask`.
- R8: Writing the initial count (0x380) loads the same value into the current count (0x390). A write to the current count alone changes only it. A `timerTick` decrements a nonzero current count and leaves zero at zero.
- R9: A write to 0x300 raises `sendReq` for one cycle, one cycle after the strobe, with `cmdWord[31:0]` already holding the new value. A write to 0x310 only updates `cmdWord[63:32]`.
- R10: With `winEnable` low, a claimed read returns zero with `rdValid` and `accErr`. A claimed write changes nothing, raises no send request and raises `accErr`.
- R11: A read of an unmapped offset returns zero with a one-cycle `accErr`. A write to an unmapped offset is ignored without error.
- R12: The field outputs follow the stored registers: `taskPrio` is 0x080[7:0], `spurVec` is 0x0F0[7:0], `swEnable` is 0x0F0[8], and `timerEntry` is 0x320. `divCfg`, `initCount` and `curCount` are full words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| winEnable | input | 1 | Global enable for the window |
| baseAddr | input | 32 | Window base; bits 31:12 used |
| busAddr | input | 32 | Access address |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, zero unless valid |
| rdValid | output | 1 | Read response valid |
| accErr | output | 1 | One-cycle access error |
| isrIn | input | 256 | In-service bitmap from the core |
| trigIn | input | 256 | Trigger-mode bitmap from the core |
| irrIn | input | 256 | Request bitmap from the core |
| timerTick | input | 1 | Current-count decrement request |
| enMask | output | 256 | Vector enable bitmap |
| taskPrio | output | 8 | Task priority |
| spurVec | output | 8 | Spurious vector |
| swEnable | output | 1 | Software enable bit |
| timerEntry | output | 32 | Timer local vector entry |
| divCfg | output | 32 | Timer divide configuration |
| initCount | output | 32 | Timer initial count |
| curCount | output | 32 | Timer current count |
| cmdWord | output | 64 | Command register, high and low words |
| sendReq | output | 1 | Send request pulse |

## Verification
The hardest case to reach from the ports is telling an ignored write apart from a stored one across all 256 slots of the window, because each register class reacts differently. The stimulus first reads every slot after reset. It then writes a distinct slot-dependent pattern to every slot in ascending order, so that the current count is written after the initial count. It then reads every slot again and compares each one against a classification computed in the bench. The core bitmaps are driven with residue patterns, so every window checks its bit-to-vector mapping.

// File: rtl/intc_regwin_pkg.sv
package intc_regwin_pkg;

  localparam int NUM_VEC = 256;
  localparam int IDX_W   = 3;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_ID, SEL_VER, SEL_TPR, SEL_RRD, SEL_LDR, SEL_DFR, SEL_SVR,
    SEL_ISR, SEL_TRG, SEL_IRR, SEL_ESR, SEL_CMDLO, SEL_CMDHI, SEL_LVT,
    SEL_INIT, SEL_CUR, SEL_DIV, SEL_IER, SEL_EXT
  } regSel_e;

  // Strobes handed from the decoder to the register file
  typedef struct packed {
    logic             rd;
    logic             wr;
    regSel_e          sel;
    logic [IDX_W-1:0] idx;
  } regStrobe_t;

endpackage

// File: rtl/intc_regwin_ctrl.sv
module intc_regwin_ctrl
  import intc_regwin_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 12,
  parameter int NUM_LVT  = 6,
  parameter int NUM_EXT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              winEnable,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  output regStrobe_t        stb,
  output logic              rdValid,
  output logic              accErr
);

  localparam int SLOT_W   = WIN_BITS - 4;
  localparam int LVT_BASE = 'h32;
  localparam int EXT_BASE = 'h50;

  logic              winHit;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] lvtOff;
  logic [SLOT_W-1:0] extOff;
  regSel_e           sel;
  logic [IDX_W-1:0]  idx;

  assign winHit = (busAddr[ADDR_W-1:WIN_BITS] == baseAddr[ADDR_W-1:WIN_BITS]);
  assign slot   = busAddr[WIN_BITS-1:4];
  assign lvtOff = slot - SLOT_W'(LVT_BASE);
  assign extOff = slot - SLOT_W'(EXT_BASE);

  always_comb begin
    sel = SEL_NONE;
    idx = slot[IDX_W-1:0];
    case (slot)
      SLOT_W'('h02): sel = SEL_ID;
      SLOT_W'('h03): sel = SEL_VER;
      SLOT_W'('h08): sel = SEL_TPR;
      SLOT_W'('h0C): sel = SEL_RRD;
      SLOT_W'('h0D): sel = SEL_LDR;
      SLOT_W'('h0E): sel = SEL_DFR;
      SLOT_W'('h0F): sel = SEL_SVR;
      SLOT_W'('h28): sel = SEL_ESR;
      SLOT_W'('h30): sel = SEL_CMDLO;
      SLOT_W'('h31): sel = SEL_CMDHI;
      SLOT_W'('h38): sel = SEL_INIT;
      SLOT_W'('h39): sel = SEL_CUR;
      SLOT_W'('h3E): sel = SEL_DIV;
      default: begin
        if (slot[SLOT_W-1:3] == (SLOT_W-3)'('h02))      sel = SEL_ISR;
        else if (slot[SLOT_W-1:3] == (SLOT_W-3)'('h03)) sel = SEL_TRG;
        else if (slot[SLOT_W-1:3] == (SLOT_W-3)'('h04)) sel = SEL_IRR;
        else if (slot[SLOT_W-1:3] == (SLOT_W-3)'('h09)) sel = SEL_IER;
        else if (int'(slot) >= LVT_BASE && int'(slot) < LVT_BASE + NUM_LVT) begin
          sel = SEL_LVT;
          idx = lvtOff[IDX_W-1:0];
        end else if (int'(slot) >= EXT_BASE && int'(slot) < EXT_BASE + NUM_EXT) begin
          sel = SEL_EXT;
          idx = extOff[IDX_W-1:0];
        end
      end
    endcase
  end

  assign stb.rd  = rdStb && winHit && winEnable;
  assign stb.wr  = wrStb && winHit && winEnable;
  assign stb.sel = sel;
  assign stb.idx = idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      accErr  <= 1'b0;
    end else begin
      rdValid <= rdStb && winHit;
      accErr  <= winHit && ((!winEnable && (rdStb || wrStb)) ||
                            (winEnable && rdStb && sel == SEL_NONE));
    end
  end

  p_err_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> $past((rdStb || wrStb) && winHit));

  p_disabled_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && winHit && !winEnable) |=> (rdValid && accErr));

  p_outside_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((rdStb || wrStb) && !winHit) |=> (!rdValid && !accErr));

endmodule

// File: rtl/intc_regwin_regs.sv
module intc_regwin_regs
  import intc_regwin_pkg::*;
#(
  parameter int          NUM_LVT     = 6,
  parameter int          NUM_EXT     = 4,
  parameter logic [31:0] VERSION_VAL = 32'h8005_0010
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  logic [31:0]        wrData,
  input  logic [NUM_VEC-1:0] isrIn,
  input  logic [NUM_VEC-1:0] trigIn,
  input  logic [NUM_VEC-1:0] irrIn,
  input  logic               timerTick,
  output logic [31:0]        rdData,
  output logic [NUM_VEC-1:0] enMask,
  output logic [31:0]        tprReg,
  output logic [31:0]        svrReg,
  output logic [31:0]        timerEntry,
  output logic [31:0]        divCfg,
  output logic [31:0]        initCount,
  output logic [31:0]        curCount,
  output logic [63:0]        cmdWord,
  output logic               sendReq
);

  localparam logic [31:0] LVT_RESET = 32'h0001_0000;
  localparam logic [31:0] DFR_RESET = 32'hFFFF_FFFF;
  localparam logic [31:0] SVR_RESET = 32'h0000_00FF;

  logic [31:0] idReg, ldrReg, dfrReg, esrReg;
  logic [31:0] lvtReg [NUM_LVT];
  logic [31:0] extReg [NUM_EXT];
  logic [31:0] readMux;
  logic [7:0]  bitBase;

  function automatic logic wrHit(regStrobe_t s, regSel_e which);
    return s.wr && (s.sel == which);
  endfunction

  assign bitBase = {stb.idx, 5'd0};

  // Scalar configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg   <= '0;
      tprReg  <= '0;
      ldrReg  <= '0;
      dfrReg  <= DFR_RESET;
      svrReg  <= SVR_RESET;
      esrReg  <= '0;
      divCfg  <= '0;
      cmdWord <= '0;
      sendReq <= 1'b0;
    end else begin
      if (wrHit(stb, SEL_ID))    idReg  <= wrData;
      if (wrHit(stb, SEL_TPR))   tprReg <= wrData;
      if (wrHit(stb, SEL_LDR))   ldrReg <= wrData;
      if (wrHit(stb, SEL_DFR))   dfrReg <= wrData;
      if (wrHit(stb, SEL_SVR))   svrReg <= wrData;
      if (wrHit(stb, SEL_ESR))   esrReg <= wrData;
      if (wrHit(stb, SEL_DIV))   divCfg <= wrData;
      if (wrHit(stb, SEL_CMDLO)) cmdWord[31:0]  <= wrData;
      if (wrHit(stb, SEL_CMDHI)) cmdWord[63:32] <= wrData;
      sendReq <= wrHit(stb, SEL_CMDLO);
    end
  end

  // Local vector entries and extended entries: plain storage
  generate
    for (genvar g = 0; g < NUM_LVT; g++) begin : gLvt
      always_ff @(posedge clk) begin
        if (!rstN) lvtReg[g] <= LVT_RESET;
        else if (wrHit(stb, SEL_LVT) && int'(stb.idx) == g) lvtReg[g] <= wrData;
      end
    end
    for (genvar g = 0; g < NUM_EXT; g++) begin : gExt
      always_ff @(posedge clk) begin
        if (!rstN) extReg[g] <= '0;
        else if (wrHit(stb, SEL_EXT) && int'(stb.idx) == g) extReg[g] <= wrData;
      end
    end
  endgenerate

  assign timerEntry = lvtReg[0];

  // Enable bitmap, written one 32-bit window at a time
  always_ff @(posedge clk) begin
    if (!rstN) enMask <= '0;
    else if (wrHit(stb, SEL_IER)) enMask[bitBase +: 32] <= wrData;
  end

  // Timer counts: initial count write reloads the current count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      initCount <= '0;
      curCount  <= '0;
    end else if (wrHit(stb, SEL_INIT)) begin
      initCount <= wrData;
      curCount  <= wrData;
    end else if (wrHit(stb, SEL_CUR)) begin
      curCount <= wrData;
    end else if (timerTick && curCount != 32'd0) begin
      curCount <= curCount - 32'd1;
    end
  end

  always_comb begin
    readMux = '0;
    unique case (stb.sel)
      SEL_ID:    readMux = idReg;
      SEL_VER:   readMux = VERSION_VAL;
      SEL_TPR:   readMux = tprReg;
      SEL_RRD:   readMux = '0;
      SEL_LDR:   readMux = ldrReg;
      SEL_DFR:   readMux = dfrReg;
      SEL_SVR:   readMux = svrReg;
      SEL_ISR:   readMux = isrIn[bitBase +: 32];
      SEL_TRG:   readMux = trigIn[bitBase +: 32];
      SEL_IRR:   readMux = irrIn[bitBase +: 32];
      SEL_ESR:   readMux = esrReg;
      SEL_CMDLO: readMux = cmdWord[31:0];
      SEL_CMDHI: readMux = cmdWord[63:32];
      SEL_LVT:   readMux = (int'(stb.idx) < NUM_LVT) ? lvtReg[stb.idx] : '0;
      SEL_INIT:  readMux = initCount;
      SEL_CUR:   readMux = curCount;
      SEL_DIV:   readMux = divCfg;
      SEL_IER:   readMux = enMask[bitBase +: 32];
      SEL_EXT:   readMux = (int'(stb.idx) < NUM_EXT) ? extReg[stb.idx] : '0;
      default:   readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= stb.rd ? readMux : '0;
  end

  p_init_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrHit(stb, SEL_INIT) |=> (curCount == initCount));

  p_tick_dec_r8: assert property (@(posedge clk) disable iff (!rstN)
    (timerTick && !stb.wr && curCount != 32'd0) |=> (curCount == $past(curCount) - 32'd1));

  p_send_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrHit(stb, SEL_CMDLO) |=> (sendReq && cmdWord[31:0] == $past(wrData)));

  p_hi_no_send_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrHit(stb, SEL_CMDHI) |=> !sendReq);

endmodule

// File: rtl/intc_regwin.sv
module intc_regwin
  import intc_regwin_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          WIN_BITS    = 12,
  parameter int          NUM_LVT     = 6,
  parameter int          NUM_EXT     = 4,
  parameter logic [31:0] VERSION_VAL = 32'h8005_0010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               winEnable,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               rdStb,
  input  logic               wrStb,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               rdValid,
  output logic               accErr,
  input  logic [NUM_VEC-1:0] isrIn,
  input  logic [NUM_VEC-1:0] trigIn,
  input  logic [NUM_VEC-1:0] irrIn,
  input  logic               timerTick,
  output logic [NUM_VEC-1:0] enMask,
  output logic [7:0]         taskPrio,
  output logic [7:0]         spurVec,
  output logic               swEnable,
  output logic [31:0]        timerEntry,
  output logic [31:0]        divCfg,
  output logic [31:0]        initCount,
  output logic [31:0]        curCount,
  output logic [63:0]        cmdWord,
  output logic               sendReq
);

  regStrobe_t  stb;
  logic [31:0] tprReg;
  logic [31:0] svrReg;

  intc_regwin_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .NUM_LVT(NUM_LVT), .NUM_EXT(NUM_EXT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .winEnable(winEnable), .baseAddr(baseAddr),
    .busAddr(busAddr), .rdStb(rdStb), .wrStb(wrStb), .stb(stb),
    .rdValid(rdValid), .accErr(accErr)
  );

  intc_regwin_regs #(
    .NUM_LVT(NUM_LVT), .NUM_EXT(NUM_EXT), .VERSION_VAL(VERSION_VAL)
  ) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .isrIn(isrIn),
    .trigIn(trigIn), .irrIn(irrIn), .timerTick(timerTick), .rdData(rdData),
    .enMask(enMask), .tprReg(tprReg), .svrReg(svrReg), .timerEntry(timerEntry),
    .divCfg(divCfg), .initCount(initCount), .curCount(curCount),
    .cmdWord(cmdWord), .sendReq(sendReq)
  );

  assign taskPrio = tprReg[7:0];
  assign spurVec  = svrReg[7:0];
  assign swEnable = svrReg[8];

  p_rddata_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == 32'd0));

  p_valid_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdStb));

endmodule

// File: tb/intc_regwin_test.sv
module intc_regwin_test;

  localparam logic [31:0] BASE  = 32'hFEE0_0000;
  localparam logic [31:0] BASE2 = 32'h1234_5000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         winEnable = 1'b1;
  logic [31:0]  baseAddr = BASE;
  logic [31:0]  busAddr = '0;
  logic         rdStb = 1'b0;
  logic         wrStb = 1'b0;
  logic [31:0]  wrData = '0;
  logic [31:0]  rdData;
  logic         rdValid, accErr;
  logic [255:0] isrIn, trigIn, irrIn;
  logic         timerTick = 1'b0;
  logic [255:0] enMask;
  logic [7:0]   taskPrio, spurVec;
  logic         swEnable;
  logic [31:0]  timerEntry, divCfg, initCount, curCount;
  logic [63:0]  cmdWord;
  logic         sendReq;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  intc_regwin uut (
    .clk(clk), .rstN(rstN), .winEnable(winEnable), .baseAddr(baseAddr),
    .busAddr(busAddr), .rdStb(rdStb), .wrStb(wrStb), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .accErr(accErr), .isrIn(isrIn),
    .trigIn(trigIn), .irrIn(irrIn), .timerTick(timerTick), .enMask(enMask),
    .taskPrio(taskPrio), .spurVec(spurVec), .swEnable(swEnable),
    .timerEntry(timerEntry), .divCfg(divCfg), .initCount(initCount),
    .curCount(curCount), .cmdWord(cmdWord), .sendReq(sendReq)
  );

  function automatic logic isrBit(int v);  return (v % 3) == 0; endfunction
  function automatic logic trigBit(int v); return (v % 5) == 1; endfunction
  function automatic logic irrBit(int v);  return (v % 7) == 2; endfunction

  initial begin
    for (int v = 0; v < 256; v++) begin
      isrIn[v]  = isrBit(v);
      trigIn[v] = trigBit(v);
      irrIn[v]  = irrBit(v);
    end
  end

  // 0 unmapped, 1 read/write, 2 read-only
  function automatic int kindOf(int s);
    if (s == 'h02 || s == 'h08 || (s >= 'h0D && s <= 'h0F) || s == 'h28 ||
        s == 'h30 || s == 'h31 || (s >= 'h32 && s <= 'h39) || s == 'h3E ||
        (s >= 'h48 && s <= 'h4F) || (s >= 'h50 && s <= 'h53)) return 1;
    if (s == 'h03 || s == 'h0C || (s >= 'h10 && s <= 'h27)) return 2;
    return 0;
  endfunction

  function automatic string tagOf(int s);
    if (s >= 'h10 && s <= 'h27) return "R6";
    if (s >= 'h48 && s <= 'h4F) return "R7";
    if (kindOf(s) == 2) return "R5";
    if (kindOf(s) == 0) return "R11";
    return "R4";
  endfunction

  function automatic logic [31:0] bitmapWord(int s);
    logic [31:0] w;
    int k;
    k = s & 7;
    for (int j = 0; j < 32; j++) begin
      if (s < 'h18)      w[j] = isrBit(32*k + j);
      else if (s < 'h20) w[j] = trigBit(32*k + j);
      else               w[j] = irrBit(32*k + j);
    end
    return w;
  endfunction

  function automatic logic [31:0] resetVal(int s);
    if (s == 'h03) return 32'h8005_0010;
    if (s == 'h0E) return 32'hFFFF_FFFF;
    if (s == 'h0F) return 32'h0000_00FF;
    if (s >= 'h32 && s <= 'h37) return 32'h0001_0000;
    if (s >= 'h10 && s <= 'h27) return bitmapWord(s);
    return 32'h0;
  endfunction

  function automatic logic [31:0] pat(int s);
    logic [31:0] t;
    t = 32'(s + 1) * 32'h9E37_79B9;
    return t ^ 32'h0F0F_0000;
  endfunction

  function automatic logic [31:0] addrOf(logic [31:0] b, int s, int lowBits);
    return b | 32'(s << 4) | 32'(lowBits & 15);
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic doRead(logic [31:0] a, output logic [31:0] d, output logic v, output logic e);
    @(negedge clk);
    busAddr = a;
    rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    d = rdData;
    v = rdValid;
    e = accErr;
  endtask

  task automatic doWrite(logic [31:0] a, logic [31:0] dat, output logic sr, output logic e);
    @(negedge clk);
    busAddr = a;
    wrData = dat;
    wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
    sr = sendReq;
    e = accErr;
  endtask

  task automatic tick();
    @(negedge clk);
    timerTick = 1'b1;
    @(negedge clk);
    timerTick = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    nChecks++;
    nFails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic v, e, sr;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: output fields after reset
    check("R1", "enMask reset", {192'd0, enMask[63:0]} == 256'd0 ? 64'd0 : 64'd1, 64'd0);
    check("R1", "spurVec reset", {56'd0, spurVec}, 64'hFF);
    check("R1", "timerEntry reset", {32'd0, timerEntry}, 64'h0001_0000);
    check("R1", "curCount reset", {32'd0, curCount}, 64'd0);
    check("R3", "rdData idle", {32'd0, rdData}, 64'd0);

    // Reset sweep over every slot of the window (low bits vary: R4)
    for (int s = 0; s < 256; s++) begin
      doRead(addrOf(BASE, s, s), d, v, e);
      check((kindOf(s) == 0) ? "R11" : "R1", $sformatf("reset slot %h data", s), {32'd0, d}, {32'd0, resetVal(s)});
      check("R3", $sformatf("slot %h valid", s), {63'd0, v}, 64'd1);
      check("R11", $sformatf("slot %h err", s), {63'd0, e}, {63'd0, kindOf(s) == 0});
    end

    // Write sweep: only 0x300 raises a send request (R9); writes never error (R11)
    for (int s = 0; s < 256; s++) begin
      doWrite(addrOf(BASE, s, 0), pat(s), sr, e);
      check("R9", $sformatf("slot %h sendReq", s), {63'd0, sr}, {63'd0, s == 'h30});
      check("R11", $sformatf("slot %h write err", s), {63'd0, e}, 64'd0);
    end

    // Read-back sweep
    for (int s = 0; s < 256; s++) begin
      logic [31:0] exp;
      doRead(addrOf(BASE, s, 0), d, v, e);
      case (kindOf(s))
        1:       exp = pat(s);
        2:       exp = resetVal(s);
        default: exp = 32'h0;
      endcase
      check(tagOf(s), $sformatf("readback slot %h", s), {32'd0, d}, {32'd0, exp});
    end

    // R12 and R7: field outputs follow stored values
    check("R12", "taskPrio", {56'd0, taskPrio}, {56'd0, pat('h08) & 32'hFF});
    check("R12", "spurVec", {56'd0, spurVec}, {56'd0, pat('h0F) & 32'hFF});
    check("R12", "swEnable", {63'd0, swEnable}, {63'd0, pat('h0F) >> 8} & 64'd1);
    check("R12", "timerEntry", {32'd0, timerEntry}, {32'd0, pat('h32)});
    check("R12", "divCfg", {32'd0, divCfg}, {32'd0, pat('h3E)});
    check("R8", "initCount", {32'd0, initCount}, {32'd0, pat('h38)});
    check("R8", "curCount own write", {32'd0, curCount}, {32'd0, pat('h39)});
    check("R9", "cmdWord", cmdWord, {pat('h31), pat('h30)});
    for (int k = 0; k < 8; k++)
      check("R7", $sformatf("enMask window %0d", k), {32'd0, enMask[32*k +: 32]}, {32'd0, pat('h48 + k)});

    // R9: high word write stores without a send request
    doWrite(addrOf(BASE, 'h31, 0), 32'hCAFE_0001, sr, e);
    check("R9", "high write no send", {63'd0, sr}, 64'd0);
    check("R9", "high word stored", cmdWord, {32'hCAFE_0001, pat('h30)});

    // R8: initial count reloads current count, tick behaviour
    doWrite(addrOf(BASE, 'h38, 0), 32'd3, sr, e);
    check("R8", "reload on init write", {32'd0, curCount}, 64'd3);
    for (int t = 2; t >= -1; t--) begin
      tick();
      check("R8", "tick", {32'd0, curCount}, (t < 0) ? 64'd0 : 64'(t));
    end
    doRead(addrOf(BASE, 'h39, 0), d, v, e);
    check("R8", "current count readback", {32'd0, d}, 64'd0);

    // R2: outside the window
    doRead(BASE + 32'h1000 + 32'h80, d, v, e);
    check("R2", "outside read valid", {63'd0, v}, 64'd0);
    check("R2", "outside read err", {63'd0, e}, 64'd0);
    doWrite(BASE + 32'h1000 + 32'h80, 32'h0000_0012, sr, e);
    check("R2", "outside write err", {63'd0, e}, 64'd0);
    check("R2", "outside write no effect", {56'd0, taskPrio}, {56'd0, pat('h08) & 32'hFF});
    baseAddr = BASE2;
    doRead(addrOf(BASE2, 'h08, 0), d, v, e);
    check("R2", "moved base read", {32'd0, d}, {32'd0, pat('h08)});
    doRead(addrOf(BASE, 'h08, 0), d, v, e);
    check("R2", "old base unclaimed", {63'd0, v}, 64'd0);
    baseAddr = BASE;

    // R10: window disabled
    winEnable = 1'b0;
    doRead(addrOf(BASE, 'h08, 0), d, v, e);
    check("R10", "disabled read data", {32'd0, d}, 64'd0);
    check("R10", "disabled read valid", {63'd0, v}, 64'd1);
    check("R10", "disabled read err", {63'd0, e}, 64'd1);
    doWrite(addrOf(BASE, 'h08, 0), 32'h0000_0077, sr, e);
    check("R10", "disabled write err", {63'd0, e}, 64'd1);
    check("R10", "disabled write no effect", {56'd0, taskPrio}, {56'd0, pat('h08) & 32'hFF});
    doWrite(addrOf(BASE, 'h30, 0), 32'h1111_2222, sr, e);
    check("R10", "disabled cmd no send", {63'd0, sr}, 64'd0);
    check("R10", "disabled cmd unchanged", cmdWord, {32'hCAFE_0001, pat('h30)});
    winEnable = 1'b1;
    doRead(addrOf(BASE, 'h08, 0), d, v, e);
    check("R10", "re-enabled readback", {32'd0, d}, {32'd0, pat('h08)});

    // R3: data returns to zero after the response cycle
    @(negedge clk);
    check("R3", "valid drops", {63'd0, rdValid}, 64'd0);
    check("R3", "data zero after", {32'd0, rdData}, 64'd0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule